// File: doc/BRIEF.md
# Byte-Stream Matrix Record Loader

This block takes one machine description at a time from an 8-bit AXI4-Stream slave. It unpacks the description into a parallel record for a downstream GF(2) solver. The record holds a light count N, a target light vector, a button count M, and one light-effect mask per button. Together the masks form an M x N bit matrix.

The stream carries each record in this order:
1. A light-count byte.
2. The target vector, padded up to whole bytes.
3. A button-count byte.
4. The button masks. Each mask is padded separately to whole bytes.

The lengths of the variable-length fields depend on counts that arrive earlier in the same stream. When the last byte of a record has been taken, the block presents the record and stops the stream. It holds the record until the consumer accepts it.

Top module: `mtx_loader`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) discards any partial record. After reset, `rec_valid` is low and `s_tready` is high, and the next byte accepted is read as a light count.
- R2: The first accepted byte is N. It is followed by ceil(N/8) target bytes. Bit j of target byte k sets light 8k+j, which appears at `rec_target[8k+j]`.
- R3: The byte after the target bytes is M. The accepted N and M appear unchanged on `rec_nlights` and `rec_nbuttons`.
- R4: M masks follow, each ceil(N/8) bytes long and each padded on its own. Bit j of byte k of mask b lands at `rec_masks[b*MAX_LIGHTS + 8k+j]`.
- R5: Padding bits are discarded. All target and mask bits at light positions N and above read as zero.
- R6: Mask rows at index M and above read as zero, even when an earlier record used those rows.
- R7: `rec_valid` rises in the cycle after the last byte of a record is accepted, and not earlier. It then stays high, with every record output stable, until a cycle with `rec_ready` high.
- R8: `s_tready` is low whenever `rec_valid` is high, so no stream byte is consumed while a record is pending.
- R9: A record with M = 0 completes on the button-count byte.
- R10: A record with N = 0 has no target bytes and no mask bytes. It completes on the button-count byte with every vector zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 8 | Stream byte |
| s_tvalid | input | 1 | Stream byte valid |
| s_tready | output | 1 | Stream byte accepted when high with s_tvalid |
| rec_valid | output | 1 | Completed record is available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_nlights | output | 8 | Light count N |
| rec_target | output | MAX_LIGHTS | Target light vector |
| rec_nbuttons | output | 8 | Button count M |
| rec_masks | output | MAX_BUTTONS*MAX_LIGHTS | Button masks, row b at bits b*MAX_LIGHTS upward |

## Verification
The bench fills padding bits with random values, so a loader that kept them would show stray high bits above N. Records with many buttons are followed by records with few, so a loader that failed to clear old rows would leak masks from the earlier record. N = 0 and M = 0 are tested directly: a loader that expected payload bytes in those cases would hang and trip the watchdog, or would swallow the next record's count byte. The bench also resets the block in the middle of a record and offers bytes while a record is pending. A loader that accepted those bytes would raise `s_tready` or change the held record.

// File: rtl/mtx_loader.sv
module mtx_loader #(
  parameter int MAX_LIGHTS  = 16,
  parameter int MAX_BUTTONS = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [7:0]                         s_tdata,
  input  logic                               s_tvalid,
  output logic                               s_tready,
  output logic                               rec_valid,
  input  logic                               rec_ready,
  output logic [7:0]                         rec_nlights,
  output logic [MAX_LIGHTS-1:0]              rec_target,
  output logic [7:0]                         rec_nbuttons,
  output logic [MAX_BUTTONS*MAX_LIGHTS-1:0]  rec_masks
);
  localparam int ML = MAX_LIGHTS;
  localparam int MB = MAX_BUTTONS;

  typedef enum logic [2:0] {S_NL, S_TGT, S_NB, S_BTN, S_DONE} st_t;
  st_t        st;
  logic [7:0] bidx, bcnt;
  logic [8:0] nsum;
  logic [7:0] nbytes;
  logic       hs, last_byte;

  assign nsum      = {1'b0, rec_nlights} + 9'd7;
  assign nbytes    = {2'b00, nsum[8:3]};
  assign last_byte = (bidx == nbytes - 8'd1);
  assign s_tready  = (st != S_DONE);
  assign rec_valid = (st == S_DONE);
  assign hs        = s_tvalid && s_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_NL;
      bidx <= '0;
      bcnt <= '0;
    end else begin
      case (st)
        S_NL: if (hs) begin
          rec_nlights <= s_tdata;
          rec_target  <= '0;
          rec_masks   <= '0;
          bidx        <= '0;
          bcnt        <= '0;
          st          <= (s_tdata == 8'd0) ? S_NB : S_TGT;
        end
        S_TGT: if (hs) begin
          for (int j = 0; j < 8; j++)
            if ((int'(bidx) * 8 + j) < int'(rec_nlights) && (int'(bidx) * 8 + j) < ML)
              rec_target[int'(bidx) * 8 + j] <= s_tdata[j];
          if (last_byte) begin
            bidx <= '0;
            st   <= S_NB;
          end else begin
            bidx <= bidx + 8'd1;
          end
        end
        S_NB: if (hs) begin
          rec_nbuttons <= s_tdata;
          st <= (s_tdata == 8'd0 || rec_nlights == 8'd0) ? S_DONE : S_BTN;
        end
        S_BTN: if (hs) begin
          for (int j = 0; j < 8; j++)
            if ((int'(bidx) * 8 + j) < int'(rec_nlights) && (int'(bidx) * 8 + j) < ML
                && int'(bcnt) < MB)
              rec_masks[int'(bcnt) * ML + int'(bidx) * 8 + j] <= s_tdata[j];
          if (last_byte) begin
            bidx <= '0;
            if (bcnt == rec_nbuttons - 8'd1) st <= S_DONE;
            else bcnt <= bcnt + 8'd1;
          end else begin
            bidx <= bidx + 8'd1;
          end
        end
        S_DONE: if (rec_ready) st <= S_NL;
        default: st <= S_NL;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (s_tready && !rec_valid));

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> ((rec_target >> rec_nlights) == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_target)
      && $stable(rec_masks) && $stable(rec_nbuttons) && $stable(rec_nlights)));

  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !s_tready);

  p_m_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_NB && hs && s_tdata == 8'd0) |=> rec_valid);
endmodule

// File: tb/mtx_loader_bench.sv
module mtx_loader_bench;
  localparam int ML = 16;
  localparam int MB = 8;

  logic clk = 0, rst = 1;
  logic [7:0] s_tdata = 0;
  logic s_tvalid = 0, rec_ready = 0;
  logic s_tready, rec_valid;
  logic [7:0] rec_nlights, rec_nbuttons;
  logic [ML-1:0] rec_target;
  logic [MB*ML-1:0] rec_masks;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mtx_loader #(.MAX_LIGHTS(ML), .MAX_BUTTONS(MB)) u_mtx_loader (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_nlights(rec_nlights),
    .rec_target(rec_target), .rec_nbuttons(rec_nbuttons), .rec_masks(rec_masks));

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ML-1:0] keep_low(logic [23:0] raw, int n);
    logic [ML-1:0] v = '0;
    for (int i = 0; i < ML; i++) if (i < n) v[i] = raw[i];
    return v;
  endfunction

  task automatic send(logic [7:0] b);
    @(negedge clk);
    while (!s_tready) @(negedge clk);
    s_tdata = b; s_tvalid = 1;
    @(negedge clk);
    s_tvalid = 0;
  endtask

  task automatic record(int n, int m);
    logic [ML-1:0] et;
    logic [MB*ML-1:0] em = '0;
    logic [23:0] raw;
    int nby = (n + 7) / 8;
    send(8'(n));
    raw = 24'($urandom);
    et = keep_low(raw, n);
    for (int k = 0; k < nby; k++) send(raw[8*k +: 8]);
    check(rec_valid == 0, "R7 early valid", rec_valid, 0);
    send(8'(m));
    if (n > 0)
      for (int b = 0; b < m; b++) begin
        raw = 24'($urandom);
        em[b*ML +: ML] = keep_low(raw, n);
        for (int k = 0; k < nby; k++) begin
          if (b == m - 1 && k == nby - 1) check(rec_valid == 0, "R7 early valid", rec_valid, 0);
          send(raw[8*k +: 8]);
        end
      end
    check(rec_valid == 1, (m == 0) ? "R9 valid" : (n == 0 ? "R10 valid" : "R7 valid"), rec_valid, 1);
    check(rec_nlights == 8'(n), "R3 nlights", rec_nlights, n);
    check(rec_nbuttons == 8'(m), "R3 nbuttons", rec_nbuttons, m);
    check(rec_target == et, "R2 R5 target", rec_target, et);
    check(rec_masks == em, "R4 R6 masks", rec_masks, em);
    // stall: offer a byte while pending
    s_tdata = 8'hA5; s_tvalid = 1;
    repeat (3) @(negedge clk);
    check(s_tready == 0, "R8 stall", s_tready, 0);
    check(rec_valid == 1 && rec_masks == em && rec_target == et, "R7 hold", rec_masks, em);
    s_tvalid = 0;
    rec_ready = 1;
    @(negedge clk);
    rec_ready = 0;
    check(rec_valid == 0 && s_tready == 1, "R7 release", rec_valid, 0);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rec_valid == 0 && s_tready == 1, "R1 reset state", {rec_valid, s_tready}, 2'b01);
    record(16, 8);
    record(3, 1);
    record(5, 0);
    record(0, 3);
    record(9, 4);
    record(1, 8);
    // reset mid-record
    send(8'd8);
    send(8'hFF);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(rec_valid == 0 && s_tready == 1, "R1 mid-record reset", {rec_valid, s_tready}, 2'b01);
    record(4, 2);
    for (int i = 0; i < 150; i++) record($urandom_range(0, ML), $urandom_range(0, MB));
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule